// File: doc/BRIEF.md
# Inclusive Shared Cache Presence Filter

This block is the tag and coherence-state side of a shared last-level cache that holds a superset of what up to four private core caches contain. Each resident line carries a valid flag, a tag, a dirty flag that stands in for data storage, and a vector of per-core presence bits. Because the vector says which cores may hold a copy, every coherence action is aimed only at those cores and is never broadcast.

Requests arrive on one valid/ready port. A fill request allocates the line here before the requesting core gets it. An evict notice tells the block that a core has dropped its copy, and may mark the line dirty. A snoop asks which cores hold a line. When a fill needs a way that is already in use, the block chooses a victim and back-invalidates exactly the cores flagged in the victim's presence vector. It holds the request port off until every targeted core has acknowledged, and it writes a dirty victim back toward memory. Every accepted request gets exactly one response pulse carrying a hit flag and a presence mask.

With the default parameters, an address splits into a byte offset in bits [5:0], a set index in bits [7:6] and a tag in bits [31:8].

Top module: `presence_filter`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid`, `wb_valid` and all `inv_valid` bits are 0, and every line is invalid, so a snoop to any address answers with hit 0 and mask 0.
- R2: A fill (`req_op` = 0) that misses installs the line and answers with hit 0 and a mask holding only the requesting core's bit (bit index = `req_core`). A tag is never resident in two ways of one set.
- R3: A fill that hits adds the requesting core's bit to the line's existing presence vector and answers with hit 1 and the new vector.
- R4: A snoop (`req_op` = 2) answers with hit 1 and the line's presence vector when the line is resident, and with hit 0 and mask 0 otherwise. It changes no state.
- R5: An evict notice (`req_op` = 1) never clears a presence bit. When it hits, it answers with hit 1 and the unchanged vector. With `req_dirty` = 1 it marks the line dirty. On a miss it answers with hit 0 and allocates nothing.
- R6: On a fill miss the victim is the lowest-numbered invalid way of the set. If no way is invalid, the victim comes from a 15-node tree pseudo-LRU per set. The tree starts at zero after reset, a node value of 0 points to the lower half, and a fill that hits or installs sets every node on its path to point away from the way used. Evict notices and snoops leave the tree unchanged.
- R7: When a valid victim has a non-zero presence vector, `inv_valid` is raised for exactly those cores, and `inv_addr` carries the victim line address. Each bit stays high until the matching `inv_ack` is seen.
- R8: While any invalidation is outstanding, `req_ready` is 0 and no response is given. The fill's response comes in the cycle after the last acknowledgement.
- R9: A dirty victim produces a one-cycle `wb_valid` pulse, in the cycle after the fill is accepted, with `wb_addr` equal to the victim line address with offset bits zero.
- R10: The byte-offset bits of `req_addr` do not affect lookup.
- R11: Any request that needs no invalidation is answered with `rsp_valid` in the cycle directly after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 2 | 0 fill, 1 evict notice, 2 snoop |
| req_core | input | 2 | Requesting core index |
| req_addr | input | 32 | Byte address of the line |
| req_dirty | input | 1 | Evict notice carries modified data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | Line was resident when the request was looked up |
| rsp_mask | output | 4 | Presence vector reported by the response |
| inv_valid | output | 4 | Per-core back-invalidation request |
| inv_addr | output | 32 | Line address being invalidated |
| inv_ack | input | 4 | Per-core invalidation acknowledge |
| wb_valid | output | 1 | One-cycle write-back pulse |
| wb_addr | output | 32 | Line address written back |

## Verification
The hardest state to reach from the ports is a full set whose pseudo-LRU victim is both dirty and shared by more than one core. Only that case exercises back-invalidation to several cores, the write-back, and the stalled port, all in one fill. The stimulus table first fills all sixteen ways of set 0 in order, with a second core hitting on the first line. It then reorders recency through fill hits, and marks that first line dirty through an evict notice, which leaves the tree unchanged. The victims of the following misses are worked out by hand from the tree rules. A final directed fill delays its acknowledgement by several cycles, to show that the port stays closed and that the response waits.

// File: rtl/pfilt_pkg.sv
package pfilt_pkg;

  typedef enum logic [1:0] {
    OP_FILL  = 2'd0,
    OP_EVICT = 2'd1,
    OP_SNOOP = 2'd2
  } pf_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_INV  = 1'b1
  } pf_state_e;

endpackage

// File: rtl/pfilt_plru.sv
module pfilt_plru #(
  parameter int WAYS = 16,
  parameter int SETS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(SETS)-1:0]   rd_set,
  output logic [$clog2(WAYS)-1:0]   victim_way,
  input  logic                      touch_en,
  input  logic [$clog2(SETS)-1:0]   touch_set,
  input  logic [$clog2(WAYS)-1:0]   touch_way
);
  localparam int WAY_W = $clog2(WAYS);
  localparam int NODES = WAYS - 1;

  logic [NODES-1:0] tree_q [SETS];

  // walk from the root; node bit 0 selects the lower half
  function automatic logic [WAY_W-1:0] tree_pick(input logic [NODES-1:0] t);
    logic [WAY_W-1:0] r;
    int idx;
    r   = '0;
    idx = 0;
    for (int l = 0; l < WAY_W; l++) begin
      r[WAY_W-1-l] = t[idx];
      idx = 2 * idx + 1 + int'(t[idx]);
    end
    return r;
  endfunction

  // every node on the path points away from the way just used
  function automatic logic [NODES-1:0] tree_touch(input logic [NODES-1:0] t,
                                                  input logic [WAY_W-1:0] w);
    logic [NODES-1:0] n;
    int idx;
    n   = t;
    idx = 0;
    for (int l = 0; l < WAY_W; l++) begin
      n[idx] = ~w[WAY_W-1-l];
      idx = 2 * idx + 1 + int'(w[WAY_W-1-l]);
    end
    return n;
  endfunction

  assign victim_way = tree_pick(tree_q[rd_set]);

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tree_q[s] <= '0;
      end else if (touch_en && (touch_set == s)) begin
        tree_q[s] <= tree_touch(tree_q[s], touch_way);
      end
    end
  end

endmodule

// File: rtl/pfilt_tags.sv
module pfilt_tags #(
  parameter int CORES = 4,
  parameter int WAYS  = 16,
  parameter int SETS  = 4,
  parameter int TAG_W = 24
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(SETS)-1:0]       lk_set,
  input  logic [TAG_W-1:0]              lk_tag,
  output logic [WAYS-1:0]               set_valid,
  output logic [WAYS-1:0]               set_dirty,
  output logic [WAYS-1:0][TAG_W-1:0]    set_tag,
  output logic [WAYS-1:0][CORES-1:0]    set_pres,
  output logic [WAYS-1:0]               hit_vec,
  output logic                          hit,
  output logic [$clog2(WAYS)-1:0]       hit_way,
  output logic                          has_free,
  output logic [$clog2(WAYS)-1:0]       free_way,
  input  logic                          wr_en,
  input  logic [$clog2(SETS)-1:0]       wr_set,
  input  logic [$clog2(WAYS)-1:0]       wr_way,
  input  logic [TAG_W-1:0]              wr_tag,
  input  logic [CORES-1:0]              wr_pres,
  input  logic                          wr_dirty
);
  localparam int WAY_W = $clog2(WAYS);

  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  dirty_q [SETS];
  logic [CORES-1:0] pres_q  [SETS][WAYS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];

  function automatic logic [WAY_W-1:0] low_index(input logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (v[i]) r = WAY_W'(i);
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) pres_q[s][w] <= '0;
      end
    end else if (wr_en) begin
      valid_q[wr_set][wr_way] <= 1'b1;
      dirty_q[wr_set][wr_way] <= wr_dirty;
      pres_q[wr_set][wr_way]  <= wr_pres;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_set][wr_way] <= wr_tag;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign set_valid[w] = valid_q[lk_set][w];
    assign set_dirty[w] = dirty_q[lk_set][w];
    assign set_tag[w]   = tag_q[lk_set][w];
    assign set_pres[w]  = pres_q[lk_set][w];
    assign hit_vec[w]   = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
  end

  assign hit      = |hit_vec;
  assign hit_way  = low_index(hit_vec);
  assign has_free = ~&set_valid;
  assign free_way = low_index(~set_valid);

endmodule

// File: rtl/pfilt_inv_track.sv
module pfilt_inv_track #(
  parameter int CORES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CORES-1:0] load_mask,
  input  logic [CORES-1:0] inv_ack,
  output logic [CORES-1:0] pending,
  output logic             done
);
  logic [CORES-1:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pend_q <= '0;
    else if (load) pend_q <= load_mask;
    else           pend_q <= pend_q & ~inv_ack;
  end

  assign pending = pend_q;
  assign done    = (|pend_q) && ((pend_q & ~inv_ack) == '0);

endmodule

// File: rtl/presence_filter.sv
module presence_filter
  import pfilt_pkg::*;
#(
  parameter int CORES  = 4,
  parameter int WAYS   = 16,
  parameter int SETS   = 4,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [1:0]                req_op,
  input  logic [$clog2(CORES)-1:0]  req_core,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic                      req_dirty,
  output logic                      rsp_valid,
  output logic                      rsp_hit,
  output logic [CORES-1:0]          rsp_mask,
  output logic [CORES-1:0]          inv_valid,
  output logic [ADDR_W-1:0]         inv_addr,
  input  logic [CORES-1:0]          inv_ack,
  output logic                      wb_valid,
  output logic [ADDR_W-1:0]         wb_addr
);
  localparam int CORE_W = $clog2(CORES);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int SET_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - SET_W;

  function automatic logic [SET_W-1:0] addr_set(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: SET_W];
  endfunction

  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [ADDR_W-1:0] line_addr(input logic [TAG_W-1:0] t,
                                                  input logic [SET_W-1:0] s);
    return {t, s, {OFF_W{1'b0}}};
  endfunction

  function automatic logic [CORES-1:0] core_bit(input logic [CORE_W-1:0] c);
    return CORES'(1) << c;
  endfunction

  pf_state_e st_q, st_d;

  logic [SET_W-1:0]  req_set, cur_set, q_set;
  logic [TAG_W-1:0]  req_tag, q_tag;
  logic [CORE_W-1:0] q_core;
  logic [WAY_W-1:0]  q_way;
  pf_op_e            op;

  logic [WAYS-1:0]             set_valid, set_dirty, hit_vec;
  logic [WAYS-1:0][TAG_W-1:0]  set_tag;
  logic [WAYS-1:0][CORES-1:0]  set_pres;
  logic                        hit, has_free;
  logic [WAY_W-1:0]            hit_way, free_way, plru_way, victim_way;

  logic             vic_valid, vic_dirty;
  logic [CORES-1:0] vic_pres, inst_bit;
  logic [TAG_W-1:0] vic_tag;

  // named events, also used by the bound checker
  logic fire, ev_fill, ev_fill_hit, ev_fill_miss, ev_need_inv, ev_wb;
  logic ev_inv_done, ev_install, ev_evict_mark, rsp_fire;

  logic             wr_en, wr_dirty;
  logic [WAY_W-1:0] wr_way;
  logic [TAG_W-1:0] wr_tag;
  logic [CORES-1:0] wr_pres;

  logic             inv_done;
  logic [CORES-1:0] pending;

  logic             rsp_valid_q, rsp_hit_q, wb_valid_q;
  logic [CORES-1:0] rsp_mask_q, rsp_mask_d;
  logic [ADDR_W-1:0] wb_addr_q, inv_addr_q;

  assign req_set   = addr_set(req_addr);
  assign req_tag   = addr_tag(req_addr);
  assign op        = pf_op_e'(req_op);
  assign req_ready = (st_q == ST_IDLE);
  assign cur_set   = (st_q == ST_INV) ? q_set : req_set;

  pfilt_tags #(.CORES(CORES), .WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_set(cur_set), .lk_tag(req_tag),
    .set_valid(set_valid), .set_dirty(set_dirty), .set_tag(set_tag), .set_pres(set_pres),
    .hit_vec(hit_vec), .hit(hit), .hit_way(hit_way),
    .has_free(has_free), .free_way(free_way),
    .wr_en(wr_en), .wr_set(cur_set), .wr_way(wr_way), .wr_tag(wr_tag),
    .wr_pres(wr_pres), .wr_dirty(wr_dirty)
  );

  pfilt_plru #(.WAYS(WAYS), .SETS(SETS)) u_plru (
    .clk(clk), .rst_n(rst_n),
    .rd_set(cur_set), .victim_way(plru_way),
    .touch_en(ev_fill_hit || ev_install), .touch_set(cur_set), .touch_way(wr_way)
  );

  pfilt_inv_track #(.CORES(CORES)) u_track (
    .clk(clk), .rst_n(rst_n),
    .load(ev_need_inv), .load_mask(vic_pres), .inv_ack(inv_ack),
    .pending(pending), .done(inv_done)
  );

  // victim: lowest free way first, otherwise the tree choice
  assign victim_way = has_free ? free_way : plru_way;
  assign vic_valid  = set_valid[victim_way];
  assign vic_dirty  = set_dirty[victim_way];
  assign vic_pres   = set_pres[victim_way];
  assign vic_tag    = set_tag[victim_way];

  assign fire          = req_valid && req_ready;
  assign ev_fill       = fire && (op == OP_FILL);
  assign ev_fill_hit   = ev_fill && hit;
  assign ev_fill_miss  = ev_fill && !hit;
  assign ev_need_inv   = ev_fill_miss && vic_valid && (|vic_pres);
  assign ev_wb         = ev_fill_miss && vic_valid && vic_dirty;
  assign ev_inv_done   = (st_q == ST_INV) && inv_done;
  assign ev_install    = (ev_fill_miss && !ev_need_inv) || ev_inv_done;
  assign ev_evict_mark = fire && (op == OP_EVICT) && hit && req_dirty;
  assign rsp_fire      = (fire && !ev_need_inv) || ev_inv_done;

  assign inst_bit = core_bit((st_q == ST_INV) ? q_core : req_core);

  always_comb begin
    wr_en    = ev_fill_hit || ev_install || ev_evict_mark;
    wr_tag   = (st_q == ST_INV) ? q_tag : req_tag;
    wr_way   = hit_way;
    wr_pres  = set_pres[hit_way];
    wr_dirty = set_dirty[hit_way];
    if (ev_install) begin
      wr_way   = (st_q == ST_INV) ? q_way : victim_way;
      wr_pres  = inst_bit;
      wr_dirty = 1'b0;
    end else if (ev_fill_hit) begin
      wr_pres  = set_pres[hit_way] | core_bit(req_core);
    end else if (ev_evict_mark) begin
      wr_dirty = 1'b1;
    end
  end

  always_comb begin
    if (ev_install || ev_fill_hit) rsp_mask_d = wr_pres;
    else if (hit)                  rsp_mask_d = set_pres[hit_way];
    else                           rsp_mask_d = '0;
  end

  always_comb begin
    st_d = st_q;
    if (ev_need_inv)      st_d = ST_INV;
    else if (ev_inv_done) st_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_mask_q  <= '0;
      wb_valid_q  <= 1'b0;
      wb_addr_q   <= '0;
      inv_addr_q  <= '0;
      q_set       <= '0;
      q_tag       <= '0;
      q_core      <= '0;
      q_way       <= '0;
    end else begin
      st_q        <= st_d;
      rsp_valid_q <= rsp_fire;
      wb_valid_q  <= ev_wb;
      if (rsp_fire) begin
        rsp_hit_q  <= (st_q == ST_IDLE) && hit;
        rsp_mask_q <= rsp_mask_d;
      end
      if (ev_wb) wb_addr_q <= line_addr(vic_tag, req_set);
      if (ev_need_inv) begin
        inv_addr_q <= line_addr(vic_tag, req_set);
        q_set      <= req_set;
        q_tag      <= req_tag;
        q_core     <= req_core;
        q_way      <= victim_way;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_mask  = rsp_mask_q;
  assign inv_valid = pending;
  assign inv_addr  = inv_addr_q;
  assign wb_valid  = wb_valid_q;
  assign wb_addr   = wb_addr_q;

endmodule

// File: rtl/pfilt_checker.sv
module pfilt_checker #(
  parameter int CORES = 4,
  parameter int WAYS  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [1:0]       req_op,
  input logic             rsp_valid,
  input logic [CORES-1:0] inv_valid,
  input logic [CORES-1:0] inv_ack,
  input logic [WAYS-1:0]  hit_vec
);

  AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R2

  AST_INV_BLOCKS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    (|inv_valid) |-> !req_ready); // R8

  AST_INV_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (|inv_valid) |-> !rsp_valid); // R8

  AST_RSP_REOPENS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready); // R8

  AST_INV_FROM_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|inv_valid) |-> $past(req_valid && req_ready && (req_op == 2'd0))); // R7

  AST_ACCEPT_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_valid || (|inv_valid))); // R11

  for (genvar c = 0; c < CORES; c++) begin : g_core
    AST_INV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid[c] && !inv_ack[c]) |=> inv_valid[c]); // R7
  end

endmodule

bind presence_filter pfilt_checker #(.CORES(CORES), .WAYS(WAYS)) u_pfilt_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .rsp_valid(rsp_valid), .inv_valid(inv_valid),
  .inv_ack(inv_ack), .hit_vec(hit_vec)
);

// File: tb/presence_filter_bench.sv
`timescale 1ns/1ps
module presence_filter_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = '0;
  logic [1:0]  req_core = '0;
  logic [31:0] req_addr = '0;
  logic        req_dirty = 1'b0;
  logic        rsp_valid, rsp_hit;
  logic [3:0]  rsp_mask, inv_valid;
  logic [3:0]  inv_ack = '0;
  logic [31:0] inv_addr, wb_addr;
  logic        wb_valid;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  presence_filter u_presence_filter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_core(req_core), .req_addr(req_addr), .req_dirty(req_dirty),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_mask(rsp_mask),
    .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_ack(inv_ack),
    .wb_valid(wb_valid), .wb_addr(wb_addr)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  core;
    logic [23:0] tag;
    logic [5:0]  off;
    logic        dirty;
    logic        hit;
    logic [3:0]  mask;
    logic        wb;
    logic [23:0] wb_tag;
    logic [3:0]  inv;
  } vec_t;

  localparam int NV = 28;
  // all in set 0: address = tag*256 + offset
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd1, 24'd1,  6'd0,  1'b0, 1'b0, 4'b0010, 1'b0, 24'd0, 4'b0000}, // R2 miss
    '{2'd0, 2'd2, 24'd1,  6'd0,  1'b0, 1'b1, 4'b0110, 1'b0, 24'd0, 4'b0000}, // R3 hit adds core
    '{2'd0, 2'd2, 24'd2,  6'd0,  1'b0, 1'b0, 4'b0100, 1'b0, 24'd0, 4'b0000},
    '{2'd0, 2'd3, 24'd3,  6'd0,  1'b0, 1'b0, 4'b1000, 1'b0, 24'd0, 4'b0000},
    '{2'd0, 2'd0, 24'd4,  6'd0,  1'b0, 1'b0, 4'b0001, 1'b0, 24'd0, 4'b0000},
    '{2'd0, 2'd1, 24'd5,  6'd0,  1'b0, 1'b0, 4'b0010, 1'b0, 24'd0, 4'b0000},
    '{2'd0, 2'd2, 24'd6,  6'd0,  1'b0, 1'b0, 4'b0100, 1'b0, 24'd0, 4'b0000},
    '{2'd0, 2'd3, 24'd7,  6'd0,  1'b0, 1'b0, 4'b1000, 1'b0, 24'd0, 4'b0000},
    '{2'd0, 2'd0, 24'd8,  6'd0,  1'b0, 1'b0, 4'b0001, 1'b0, 24'd0, 4'b0000},
    '{2'd0, 2'd1, 24'd9,  6'd0,  1'b0, 1'b0, 4'b0010, 1'b0, 24'd0, 4'b0000},
    '{2'd0, 2'd2, 24'd10, 6'd0,  1'b0, 1'b0, 4'b0100, 1'b0, 24'd0, 4'b0000},
    '{2'd0, 2'd3, 24'd11, 6'd0,  1'b0, 1'b0, 4'b1000, 1'b0, 24'd0, 4'b0000},
    '{2'd0, 2'd0, 24'd12, 6'd0,  1'b0, 1'b0, 4'b0001, 1'b0, 24'd0, 4'b0000},
    '{2'd0, 2'd1, 24'd13, 6'd0,  1'b0, 1'b0, 4'b0010, 1'b0, 24'd0, 4'b0000},
    '{2'd0, 2'd2, 24'd14, 6'd0,  1'b0, 1'b0, 4'b0100, 1'b0, 24'd0, 4'b0000},
    '{2'd0, 2'd3, 24'd15, 6'd0,  1'b0, 1'b0, 4'b1000, 1'b0, 24'd0, 4'b0000},
    '{2'd0, 2'd0, 24'd16, 6'd0,  1'b0, 1'b0, 4'b0001, 1'b0, 24'd0, 4'b0000}, // set full
    '{2'd2, 2'd0, 24'd5,  6'd0,  1'b0, 1'b1, 4'b0010, 1'b0, 24'd0, 4'b0000}, // R4 snoop hit
    '{2'd0, 2'd2, 24'd5,  6'd0,  1'b0, 1'b1, 4'b0110, 1'b0, 24'd0, 4'b0000}, // R3
    '{2'd1, 2'd1, 24'd1,  6'd0,  1'b1, 1'b1, 4'b0110, 1'b0, 24'd0, 4'b0000}, // R5 dirty mark
    '{2'd1, 2'd3, 24'd3,  6'd0,  1'b0, 1'b1, 4'b1000, 1'b0, 24'd0, 4'b0000}, // R5 bit kept
    '{2'd2, 2'd0, 24'd99, 6'd0,  1'b0, 1'b0, 4'b0000, 1'b0, 24'd0, 4'b0000}, // R4 snoop miss
    '{2'd0, 2'd3, 24'd17, 6'd0,  1'b0, 1'b0, 4'b1000, 1'b0, 24'd0, 4'b0010}, // R6 victim way 8
    '{2'd0, 2'd0, 24'd33, 6'd0,  1'b0, 1'b0, 4'b0001, 1'b1, 24'd1, 4'b0110}, // R7 R9 way 0
    '{2'd2, 2'd0, 24'd1,  6'd0,  1'b0, 1'b0, 4'b0000, 1'b0, 24'd0, 4'b0000}, // R7 line gone
    '{2'd2, 2'd0, 24'd5,  6'd63, 1'b0, 1'b1, 4'b0110, 1'b0, 24'd0, 4'b0000}, // R10 offset
    '{2'd1, 2'd0, 24'd1,  6'd0,  1'b1, 1'b0, 4'b0000, 1'b0, 24'd0, 4'b0000}, // R5 evict miss
    '{2'd2, 2'd0, 24'd1,  6'd0,  1'b0, 1'b0, 4'b0000, 1'b0, 24'd0, 4'b0000}  // R5 no alloc
  };

  logic        g_hit, g_wb, g_ready_bad, g_rsp_early;
  logic [3:0]  g_mask, g_inv;
  logic [31:0] g_wb_addr, g_inv_addr;
  int          g_wait;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic run_req(input logic [1:0] op, input logic [1:0] core,
                         input logic [31:0] addr, input logic dirty, input int ack_dly);
    int inv_cycles;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_core = core; req_addr = addr; req_dirty = dirty;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    g_hit = 1'b0; g_mask = '0; g_wb = 1'b0; g_wb_addr = '0; g_inv = '0;
    g_inv_addr = '0; g_ready_bad = 1'b0; g_rsp_early = 1'b0; g_wait = 0;
    inv_cycles = 0;
    for (int n = 1; n <= 60; n++) begin
      if (wb_valid) begin g_wb = 1'b1; g_wb_addr = wb_addr; end
      if (|inv_valid) begin
        g_inv = g_inv | inv_valid;
        g_inv_addr = inv_addr;
        if (req_ready) g_ready_bad = 1'b1;
        if (rsp_valid) g_rsp_early = 1'b1;
        inv_cycles++;
        inv_ack = (inv_cycles > ack_dly) ? inv_valid : 4'b0000;
      end else begin
        inv_ack = 4'b0000;
      end
      if (rsp_valid) begin
        g_hit = rsp_hit; g_mask = rsp_mask; g_wait = n;
        break;
      end
      @(negedge clk);
    end
    inv_ack = 4'b0000;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state at the ports
    chk(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
    chk({rsp_valid, wb_valid, inv_valid} == 6'd0, "R1 outputs idle",
        64'({rsp_valid, wb_valid, inv_valid}), 64'd0);
    rst_n = 1'b1;
    run_req(2'd2, 2'd0, 32'h0000_0100, 1'b0, 0);
    chk({g_hit, g_mask} == 5'd0, "R1 snoop after reset misses", 64'({g_hit, g_mask}), 64'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      int exp_wait;
      v = VECS[i];
      run_req(v.op, v.core, {v.tag, 2'b00, v.off}, v.dirty, 0);
      exp_wait = (v.inv != 4'b0000) ? 2 : 1;
      chk(g_hit == v.hit, $sformatf("R2 R3 R4 R5 hit vec %0d", i), 64'(g_hit), 64'(v.hit));
      chk(g_mask == v.mask, $sformatf("R2 R3 R4 R5 mask vec %0d", i), 64'(g_mask), 64'(v.mask));
      chk(g_inv == v.inv, $sformatf("R6 R7 inv targets vec %0d", i), 64'(g_inv), 64'(v.inv));
      chk(g_wb == v.wb, $sformatf("R9 wb pulse vec %0d", i), 64'(g_wb), 64'(v.wb));
      if (v.wb)
        chk(g_wb_addr == {v.wb_tag, 8'h00}, $sformatf("R9 wb addr vec %0d", i),
            64'(g_wb_addr), 64'({v.wb_tag, 8'h00}));
      chk(g_wait == exp_wait, $sformatf("R11 R8 rsp timing vec %0d", i),
          64'(g_wait), 64'(exp_wait));
    end

    // R7 R8: victim tag 13 (core 1 only), acknowledgement held back 4 cycles
    run_req(2'd0, 2'd2, {24'd50, 8'h00}, 1'b0, 4);
    chk(g_inv == 4'b0010, "R7 delayed-ack targets", 64'(g_inv), 64'b0010);
    chk(g_inv_addr == {24'd13, 8'h00}, "R7 inv addr", 64'(g_inv_addr), 64'({24'd13, 8'h00}));
    chk(!g_ready_bad, "R8 ready low while invalidating", 64'(g_ready_bad), 64'd0);
    chk(!g_rsp_early, "R8 no rsp while invalidating", 64'(g_rsp_early), 64'd0);
    chk(g_wait == 6, "R8 rsp after last ack", 64'(g_wait), 64'd6);
    chk({g_hit, g_mask} == 5'b00100, "R2 delayed fill mask", 64'({g_hit, g_mask}), 64'b00100);
    chk(g_wb == 1'b0, "R9 clean victim no wb", 64'(g_wb), 64'd0);

    // R6: other set has free ways, so no victim and no invalidation
    run_req(2'd0, 2'd0, {24'd2, 2'b01, 6'd0}, 1'b0, 0);
    chk(g_inv == 4'b0000 && g_wait == 1, "R6 free way in set 1", 64'(g_inv), 64'd0);
    run_req(2'd2, 2'd3, {24'd2, 2'b01, 6'd17}, 1'b0, 0);
    chk({g_hit, g_mask} == 5'b10001, "R10 R4 snoop set 1", 64'({g_hit, g_mask}), 64'b10001);
    run_req(2'd2, 2'd3, {24'd2, 8'h00}, 1'b0, 0);
    chk({g_hit, g_mask} == 5'b10100, "R4 set 0 tag 2 unaffected", 64'({g_hit, g_mask}),
        64'b10100);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule